// File: doc/BRIEF.md
# 12-Hour BCD Clock Counter

This block is the counting core of a 12-hour digital clock. A single enable input pulses once per second (at most once per clock cycle). From it the block keeps seconds, minutes and hours as decimal digits. Seconds and minutes are each a pair of cascaded stages. A units decade counter runs 0 to 9, and a tens counter is truncated to 0 to 5, so each pair has a modulus of 60. Hours run 01 through 12 and then go back to 01.

All state sits in one clock domain. A lower stage never clocks the next one. It only supplies that stage's count enable. The carries from the seconds chain and the minutes chain are brought out as single-cycle pulses, so a neighbour can use them without decoding the digits. A synchronous reset loads 12:00:00.

Top module: `clock12_bcd_core`

## Requirements
- R1: When `rst` is high at a rising edge, the time after that edge is 12:00:00 (hours tens 1, hours units 2, every other digit 0). While `rst` is high, both carry outputs are low.
- R2: On each edge where a units digit of seconds or minutes is enabled, it advances by one, and from 9 it goes to 0.
- R3: A tens digit of seconds or minutes advances only at an enabled edge where its units digit is 9. It counts 0 to 5, so 59 is followed by 00.
- R4: `sec_tick_out` is high during exactly those cycles in which `tick` is high, `rst` is low and the seconds read 59. The minutes stage is enabled only in those cycles.
- R5: `min_tick_out` is high during exactly those cycles in which `sec_tick_out` is high and the minutes read 59. The hours stage is enabled only in those cycles.
- R6: Hours take the values 01 through 12. An enabled hours stage goes from 12 to 01 and from 09 to 10, and otherwise adds one to the units digit.
- R7: At an edge with `tick` low and `rst` low, no digit changes.
- R8: Each digit is 4-bit BCD (values 0 to 9), with the least significant bit at bit 0. The hours tens digit is only ever 0 or 1.
- R9: With no reset in between, consecutive `min_tick_out` pulses are exactly 3600 ticks apart, counting the tick in the pulse cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous reset to 12:00:00, active high |
| tick | input | 1 | One-per-second count enable |
| hr_tens | output | 4 | Hours tens digit (0 or 1) |
| hr_ones | output | 4 | Hours units digit |
| min_tens | output | 4 | Minutes tens digit (0 to 5) |
| min_ones | output | 4 | Minutes units digit |
| sec_tens | output | 4 | Seconds tens digit (0 to 5) |
| sec_ones | output | 4 | Seconds units digit |
| sec_tick_out | output | 1 | Seconds-to-minutes carry pulse |
| min_tick_out | output | 1 | Minutes-to-hours carry pulse |

## Verification
The digits are registered. A tick or reset seen at a rising edge shows up in the digits just after that edge, one cycle after it is driven. The two carries are combinational from `tick` and the current digits, so they are due in the same cycle that `tick` is driven. The bench drives inputs on the falling edge and samples one nanosecond later, when the carries reflect the new `tick` and the digits still hold the state before the coming edge. It then applies the same inputs to its own time model at the rising edge, so that every digit comparison made on the next falling edge lines up with exactly one register stage.

// File: rtl/clock12_bcd_core.sv
module clock12_bcd_core (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic       sec_tick_out,
  output logic       min_tick_out
);
  localparam logic [3:0] UNITS_TOP = 4'd9;
  localparam logic [3:0] TENS_TOP  = 4'd5;

  logic s_ones_top, m_ones_top, at_twelve;

  assign s_ones_top   = (sec_ones == UNITS_TOP);
  assign m_ones_top   = (min_ones == UNITS_TOP);
  assign at_twelve    = (hr_tens == 4'd1) && (hr_ones == 4'd2);
  assign sec_tick_out = tick && !rst && s_ones_top && (sec_tens == TENS_TOP);
  assign min_tick_out = sec_tick_out && m_ones_top && (min_tens == TENS_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_ones <= 4'd0;
      sec_tens <= 4'd0;
    end else if (tick) begin
      sec_ones <= s_ones_top ? 4'd0 : sec_ones + 4'd1;
      if (s_ones_top)
        sec_tens <= (sec_tens == TENS_TOP) ? 4'd0 : sec_tens + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min_ones <= 4'd0;
      min_tens <= 4'd0;
    end else if (sec_tick_out) begin
      min_ones <= m_ones_top ? 4'd0 : min_ones + 4'd1;
      if (m_ones_top)
        min_tens <= (min_tens == TENS_TOP) ? 4'd0 : min_tens + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_tens <= 4'd1;
      hr_ones <= 4'd2;
    end else if (min_tick_out) begin
      if (at_twelve) begin
        hr_tens <= 4'd0;
        hr_ones <= 4'd1;
      end else if (hr_ones == UNITS_TOP) begin
        hr_tens <= 4'd1;
        hr_ones <= 4'd0;
      end else begin
        hr_ones <= hr_ones + 4'd1;
      end
    end
  end
endmodule

// File: rtl/clock12_bcd_checker.sv
module clock12_bcd_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones,
  input logic       sec_tick_out,
  input logic       min_tick_out
);
  assert_reset_time_R1: assert property (@(posedge clk)
    rst |=> (hr_tens == 4'd1 && hr_ones == 4'd2 && min_tens == 4'd0 &&
             min_ones == 4'd0 && sec_tens == 4'd0 && sec_ones == 4'd0));

  assert_units_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && sec_ones == 4'd9) |=> (sec_ones == 4'd0));

  assert_tens_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (sec_ones != 4'd9) |=> $stable(sec_tens));

  assert_sec_carry_clears_R4: assert property (@(posedge clk) disable iff (rst)
    sec_tick_out |=> (sec_tens == 4'd0 && sec_ones == 4'd0));

  assert_min_carry_needs_sec_R5: assert property (@(posedge clk) disable iff (rst)
    min_tick_out |-> sec_tick_out);

  assert_hour_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (min_tick_out && hr_tens == 4'd1 && hr_ones == 4'd2) |=>
      (hr_tens == 4'd0 && hr_ones == 4'd1));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(sec_ones) && $stable(sec_tens) && $stable(min_ones) &&
               $stable(min_tens) && $stable(hr_ones) && $stable(hr_tens)));

  assert_digit_range_R8: assert property (@(posedge clk) disable iff (rst)
    (sec_ones <= 4'd9 && min_ones <= 4'd9 && hr_ones <= 4'd9 &&
     sec_tens <= 4'd5 && min_tens <= 4'd5 && hr_tens <= 4'd1 &&
     !(hr_tens == 4'd0 && hr_ones == 4'd0) && !(hr_tens == 4'd1 && hr_ones > 4'd2)));
endmodule

bind clock12_bcd_core clock12_bcd_checker chk (.*);

// File: tb/tb_clock12_bcd_core.sv
`timescale 1ns/1ps
module tb_clock12_bcd_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;
  logic sec_tick_out, min_tick_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int h = 12, m = 0, s = 0;
  int ticks_since = 0;
  bit interval_valid = 1'b0;

  always #2.5 clk = ~clk;

  clock12_bcd_core dut (
    .clk(clk), .rst(rst), .tick(tick),
    .hr_tens(hr_tens), .hr_ones(hr_ones),
    .min_tens(min_tens), .min_ones(min_ones),
    .sec_tens(sec_tens), .sec_ones(sec_ones),
    .sec_tick_out(sec_tick_out), .min_tick_out(min_tick_out)
  );

  function automatic bit exp_sec_carry(bit t, bit r);
    return t && !r && (s == 59);
  endfunction

  function automatic bit exp_min_carry(bit t, bit r);
    return exp_sec_carry(t, r) && (m == 59);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (model %0d:%0d:%0d)",
               req, what, act, exp, h, m, s);
    end
  endtask

  task automatic compare_all();
    check("R2", "sec_ones", int'(sec_ones), s % 10);
    check("R3", "sec_tens", int'(sec_tens), s / 10);
    check("R2", "min_ones", int'(min_ones), m % 10);
    check("R3", "min_tens", int'(min_tens), m / 10);
    check("R6", "hr_ones", int'(hr_ones), h % 10);
    check("R8", "hr_tens", int'(hr_tens), h / 10);
    check("R4", "sec_tick_out", int'(sec_tick_out), int'(exp_sec_carry(tick, rst)));
    check("R5", "min_tick_out", int'(min_tick_out), int'(exp_min_carry(tick, rst)));
    if (min_tick_out && interval_valid)
      check("R9", "ticks between minute carries", ticks_since + 1, 3600);
  endtask

  task automatic advance_model();
    bit sc, mc;
    sc = exp_sec_carry(tick, rst);
    mc = exp_min_carry(tick, rst);
    if (rst) begin
      h = 12; m = 0; s = 0;
      ticks_since = 0; interval_valid = 1'b0;
      return;
    end
    if (mc) begin
      ticks_since = 0; interval_valid = 1'b1;
    end else if (tick) begin
      ticks_since++;
    end
    if (tick) s = (s + 1) % 60;
    if (sc) m = (m + 1) % 60;
    if (mc) h = (h == 12) ? 1 : h + 1;
  endtask

  task automatic step(bit r, bit t);
    @(negedge clk);
    rst = r;
    tick = t;
    #1;
    compare_all();
    @(posedge clk);
    advance_model();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    @(negedge clk); #1;
    check("R1", "reset hr_tens", int'(hr_tens), 1);
    check("R1", "reset hr_ones", int'(hr_ones), 2);
    check("R1", "reset sec_ones", int'(sec_ones), 0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
    check("R7", "seconds after idle", int'(sec_ones), 0);
    for (int i = 0; i < 50000; i++) step(1'b0, ($urandom % 10) != 0);
    step(1'b1, 1'b1);
    @(negedge clk); #1;
    check("R1", "mid-run reset min_tens", int'(min_tens), 0);
    check("R1", "mid-run reset hr_ones", int'(hr_ones), 2);
    for (int i = 0; i < 7300; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b0, ($urandom % 3) == 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule